// File: doc/BRIEF.md
# Zero-Crossing Timing Quality Detector

This block grades every received signal transition by its timing. The clock recovery loop supplies a strobe on each detected zero crossing, together with the value its bit-phase counter held at that moment. The block measures how far that counter value is from the phase at which a crossing is expected. It marks the crossing GOOD when the distance falls inside a symmetric tolerance window, and BAD otherwise. The result does not depend on signal amplitude.

The single output is a logic level. It goes high after an unbroken run of good crossings and falls on the first bad one. Downstream logic can low-pass filter this pulse-density signal to obtain a signal-to-noise figure. While the recovery loop freewheels in hold mode, its phase carries no information, so the output is forced low. The block shares the bit-clock timing of the recovery loop and adds one register stage of latency.

Top module: `sn_quality_det`

## Requirements
- R1: While `rst_n` is low at a clock edge, `quality_o` becomes 0 and the run of good crossings is cleared.
- R2: A crossing is GOOD when the signed phase error is within ±`TOL`, and BAD otherwise. The error is (`xing_phase_i` − `EXP_PHASE`) modulo 2^`PHASE_W`, read as a `PHASE_W`-bit two's-complement value. The defaults are `PHASE_W`=7 (128 counts per bit), `TOL`=16 (1/8 bit), and `EXP_PHASE`=0.
- R3: A BAD crossing drives `quality_o` to 0 and clears the run of good crossings.
- R4: After a BAD crossing, reset or hold, `quality_o` stays 0 until `GOOD_RUN` consecutive GOOD crossings (default 2) have been seen. It rises on the last of them.
- R5: While `quality_o` is 1, every further GOOD crossing keeps it at 1.
- R6: In a cycle without `xing_stb_i`, `quality_o` keeps its level, whatever value `xing_phase_i` has.
- R7: While `loop_hold_i` is 1, `quality_o` becomes 0 and the run is cleared. Crossing strobes in the same cycle are ignored.
- R8: The update caused by a strobe appears on `quality_o` at the first rising clock edge on which the strobe is sampled. Before that edge, the old level is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the recovery loop |
| rst_n | input | 1 | Synchronous active-low reset |
| xing_stb_i | input | 1 | One-cycle pulse per detected zero crossing |
| xing_phase_i | input | PHASE_W | Recovery loop phase counter value at the crossing |
| loop_hold_i | input | 1 | Recovery loop is freewheeling in hold mode |
| quality_o | output | 1 | High during a run of good crossings, low after a bad one |

## Verification
The bench builds the block with `PHASE_W`=7, `TOL`=16 and `GOOD_RUN`=2, and moves `EXP_PHASE` to 120. With that offset the tolerance window wraps through counter zero, so the modulo error path must be correct on both edges of the window. The 128-count phase space is small, so the bench sweeps every phase value from both output states, low after a bad crossing and high after a good run. Each result is compared with an error computed in integer arithmetic. Directed sequences cover idle cycles with a changing phase input, hold with strobes present, and the cycle-exact timing of each update.

// File: rtl/sn_quality_pkg.sv
// Package: shared types for the zero-crossing timing quality detector.
// Assumes nothing beyond standard SystemVerilog.
package sn_quality_pkg;

    // Verdict on a single crossing.
    typedef enum logic {
        XING_BAD  = 1'b0,
        XING_GOOD = 1'b1
    } xing_class_e;

endpackage

// File: rtl/sn_phase_window.sv
// Module: sn_phase_window
// Purpose: grades one crossing by its phase distance from the expected phase.
// The difference is taken modulo 2^PHASE_W and read as two's complement. A
// crossing is GOOD when the magnitude of that difference is at most TOL.
// Assumes: TOL < 2^(PHASE_W-1), and EXP_PHASE is in 0 .. 2^PHASE_W-1.
// The logic is purely combinational.
module sn_phase_window
    import sn_quality_pkg::*;
#(
    parameter int PHASE_W   = 7,
    parameter int EXP_PHASE = 0,
    parameter int TOL       = 16
) (
    input  logic [PHASE_W-1:0] phase_i,
    output logic [PHASE_W-1:0] abs_err_o,
    output xing_class_e        cls_o
);

    localparam logic [PHASE_W-1:0] EXP_L = PHASE_W'(EXP_PHASE);
    localparam logic [PHASE_W-1:0] TOL_L = PHASE_W'(TOL);

    logic [PHASE_W-1:0] diff;

    // Difference against the expected phase, then its magnitude.
    always_comb begin
        diff      = phase_i - EXP_L;
        abs_err_o = diff[PHASE_W-1] ? (~diff + 1'b1) : diff;
    end

    // Compare the magnitude with the tolerance window.
    always_comb begin
        cls_o = (abs_err_o <= TOL_L) ? XING_GOOD : XING_BAD;
    end

endmodule

// File: rtl/sn_run_filter.sv
// Module: sn_run_filter
// Purpose: turns per-crossing verdicts into the quality level. A BAD verdict
// pulls the level low. GOOD_RUN consecutive GOOD verdicts raise it again.
// Hold mode forces the level low and clears the run.
// Assumes: GOOD_RUN >= 1, and at most one strobe per clock cycle.
module sn_run_filter
    import sn_quality_pkg::*;
#(
    parameter int GOOD_RUN = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_i,
    input  logic        stb_i,
    input  xing_class_e cls_i,
    output logic        level_o
);

    localparam int              CNT_W = $clog2(GOOD_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_L = CNT_W'(GOOD_RUN);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_inc;

    // Next run length on a GOOD crossing, saturating at the target.
    always_comb begin
        run_inc = (run_cnt == RUN_L) ? run_cnt : run_cnt + 1'b1;
    end

    // Run counter and output level register.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            run_cnt <= '0;
            level_o <= 1'b0;
        end else if (stb_i) begin
            if (cls_i == XING_GOOD) begin
                run_cnt <= run_inc;
                level_o <= (run_inc == RUN_L);
            end else begin
                run_cnt <= '0;
                level_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sn_quality_det.sv
// Module: sn_quality_det (top)
// Purpose: zero-crossing timing quality detector. It grades each crossing
// against the phase the recovery loop expects and drives a pulse-density
// quality level.
// Assumes: xing_phase_i is valid in any cycle where xing_stb_i is high, and
// all inputs are synchronous to clk.
module sn_quality_det
    import sn_quality_pkg::*;
#(
    parameter int PHASE_W   = 7,
    parameter int EXP_PHASE = 0,
    parameter int TOL       = 16,
    parameter int GOOD_RUN  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xing_stb_i,
    input  logic [PHASE_W-1:0] xing_phase_i,
    input  logic               loop_hold_i,
    output logic               quality_o
);

    xing_class_e        xing_cls;
    logic [PHASE_W-1:0] xing_abs_err;

    // Combinational grading of the current crossing.
    sn_phase_window #(
        .PHASE_W  (PHASE_W),
        .EXP_PHASE(EXP_PHASE),
        .TOL      (TOL)
    ) win_i (
        .phase_i  (xing_phase_i),
        .abs_err_o(xing_abs_err),
        .cls_o    (xing_cls)
    );

    // Registered run tracking and output level.
    sn_run_filter #(
        .GOOD_RUN(GOOD_RUN)
    ) run_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (loop_hold_i),
        .stb_i  (xing_stb_i),
        .cls_i  (xing_cls),
        .level_o(quality_o)
    );

endmodule

// File: rtl/sn_quality_chk.sv
// Module: sn_quality_chk
// Purpose: assertion checker for sn_quality_det, attached through bind.
// It grades crossings on its own from the port values and compares the
// result with the grading block inside the design.
module sn_quality_chk
    import sn_quality_pkg::*;
#(
    parameter int PHASE_W   = 7,
    parameter int EXP_PHASE = 0,
    parameter int TOL       = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               xing_stb_i,
    input logic [PHASE_W-1:0] xing_phase_i,
    input logic               loop_hold_i,
    input logic               quality_o,
    input xing_class_e        xing_cls
);

    logic signed [PHASE_W-1:0] serr;
    logic                      chk_good;

    // Independent signed-error grading from the port values.
    always_comb begin
        serr     = xing_phase_i - PHASE_W'(EXP_PHASE);
        chk_good = (int'(serr) <= TOL) && (int'(serr) >= -TOL);
    end

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !quality_o); // R1

    AST_CLASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        xing_stb_i |-> ((xing_cls == XING_GOOD) == chk_good)); // R2

    AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xing_stb_i && !chk_good) |=> !quality_o); // R3

    AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quality_o) |-> $past(xing_stb_i && chk_good && !loop_hold_i)); // R4

    AST_GOOD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (quality_o && xing_stb_i && chk_good && !loop_hold_i) |=> quality_o); // R5

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xing_stb_i && !loop_hold_i) |=> $stable(quality_o)); // R6

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        loop_hold_i |=> !quality_o); // R7

endmodule

bind sn_quality_det sn_quality_chk #(
    .PHASE_W  (PHASE_W),
    .EXP_PHASE(EXP_PHASE),
    .TOL      (TOL)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .xing_stb_i  (xing_stb_i),
    .xing_phase_i(xing_phase_i),
    .loop_hold_i (loop_hold_i),
    .quality_o   (quality_o),
    .xing_cls    (xing_cls)
);

// File: tb/sn_quality_det_tb_top.sv
// Bench: exhaustive phase sweep of sn_quality_det with the window wrapping
// through counter zero. Expected values are computed in integer arithmetic.
module sn_quality_det_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 7;
    localparam int EXP  = 120;
    localparam int TOLV = 16;
    localparam int RUN  = 2;
    localparam int SPAN = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [PW-1:0] phase = '0;
    logic          hold = 1'b0;
    logic          q;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sn_quality_det #(
        .PHASE_W(PW), .EXP_PHASE(EXP), .TOL(TOLV), .GOOD_RUN(RUN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .xing_stb_i(stb), .xing_phase_i(phase),
        .loop_hold_i(hold), .quality_o(q)
    );

    // Expected verdict from the signed modulo error.
    function automatic bit is_good(int p);
        int e;
        e = (p - EXP) % SPAN;
        if (e < 0) e += SPAN;
        if (e >= SPAN/2) e -= SPAN;
        return (e <= TOLV) && (e >= -TOLV);
    endfunction

    task automatic check(bit exp_v, string req);
        n_checks++;
        if (q !== exp_v) begin
            n_errors++;
            $display("FAIL %s: quality_o=%b expected %b at %0t", req, q, exp_v, $time);
        end
    endtask

    // One cycle of stimulus, driven at negedge; returns at the next negedge.
    task automatic cycle(bit s, int p, bit h);
        @(negedge clk);
        stb = s; phase = PW'(p); hold = h;
        @(negedge clk);
        stb = 1'b0; hold = 1'b0;
    endtask

    localparam int BADP  = (EXP + SPAN/2) % SPAN;
    localparam int GOODP = EXP;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: quality_o=%b expected completion", q);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1'b0, "R1");
        rst_n = 1'b1;
        cycle(1'b0, 0, 1'b0);
        check(1'b0, "R1");
        // R4: two goods after reset
        cycle(1'b1, GOODP, 1'b0);
        check(1'b0, "R4");
        cycle(1'b1, GOODP, 1'b0);
        check(1'b1, "R4");

        // R2/R3/R4 sweep from the low state: bad, good, p
        for (int p = 0; p < SPAN; p++) begin
            cycle(1'b1, BADP, 1'b0);
            check(1'b0, "R3");
            cycle(1'b1, GOODP, 1'b0);
            check(1'b0, "R4");
            cycle(1'b1, p, 1'b0);
            check(is_good(p), "R2");
        end

        // R2/R3/R5 sweep from the high state: bad, good, good, p
        for (int p = 0; p < SPAN; p++) begin
            cycle(1'b1, BADP, 1'b0);
            cycle(1'b1, GOODP, 1'b0);
            cycle(1'b1, GOODP, 1'b0);
            check(1'b1, "R5");
            cycle(1'b1, p, 1'b0);
            check(is_good(p), "R2");
        end

        // R6: idle cycles with a wandering phase keep both levels
        cycle(1'b1, GOODP, 1'b0);
        cycle(1'b1, GOODP, 1'b0);
        for (int p = 0; p < SPAN; p += 7) begin
            cycle(1'b0, p, 1'b0);
            check(1'b1, "R6");
        end
        cycle(1'b1, BADP, 1'b0);
        for (int p = 0; p < SPAN; p += 9) begin
            cycle(1'b0, p, 1'b0);
            check(1'b0, "R6");
        end

        // R7: hold forces low, strobes during hold are ignored
        cycle(1'b1, GOODP, 1'b0);
        cycle(1'b1, GOODP, 1'b0);
        check(1'b1, "R7");
        cycle(1'b1, GOODP, 1'b1);
        check(1'b0, "R7");
        cycle(1'b1, GOODP, 1'b1);
        check(1'b0, "R7");
        cycle(1'b1, GOODP, 1'b0);
        check(1'b0, "R7");
        cycle(1'b1, GOODP, 1'b0);
        check(1'b1, "R7");

        // R8: level unchanged before the edge, updated right after it
        @(negedge clk);
        stb = 1'b1; phase = PW'(BADP);
        #1;
        check(1'b1, "R8");
        @(posedge clk);
        #1;
        check(1'b0, "R8");
        @(negedge clk);
        stb = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule